// File: doc/BRIEF.md
# Four-Channel Byte-Programmed DMA Register File

This block is the configuration side of a four-channel, byte-wide DMA controller in the classic style, with the page registers that extend each channel's address folded in. A host reaches it through a plain 8-bit I/O write port made of address, data and a write strobe. Each channel keeps a 16-bit address, a 16-bit count, an 8-bit page, a six-bit mode and a mask bit. The block decodes all of these and drives them, channel by channel, to a transfer engine that sits beside it.

The 16-bit values are loaded one byte at a time through a single port per register. A shared byte pointer decides whether a write lands in the low or the high byte. Every address or count write flips the pointer, and a dedicated port clears it. Mode and single-mask writes name their target channel in the low two bits of the data byte. Other control ports clear or load all the masks at once, or perform a soft master reset.

Top module: `dma_cfg_regfile`

## Requirements
- R1: After reset every address, count, page and mode output is zero and every channel's enable is low (all masked).
- R2: A write to port 2n (n = 0..3) loads channel n's address: the low byte when the byte pointer is clear, the high byte when it is set. The base and current address copies both take the byte, and the other byte is kept.
- R3: A write to port 2n+1 loads channel n's count under the same low/high rule, into both the base and the current count copies.
- R4: One byte pointer is shared by all eight address and count ports, and every such write flips it. A write of any value to port 0x0C clears it.
- R5: The page ports are 0x87, 0x83, 0x81 and 0x82 for channels 0, 1, 2 and 3. The 24-bit start address output is the page above the 16-bit base address.
- R6: A write to port 0x0B loads the mode of the channel given by data bits 1:0 and leaves the other channels alone. Bits 3:2 are the direction (01 into memory, 10 out of memory), bit 4 is auto-initialisation, bit 5 is a decrementing address, and bits 7:6 are the transfer type (01 single, 10 block, 11 cascade).
- R7: A write to port 0x0A sets the mask of the channel in data bits 1:0 to data bit 2 (1 masks). Each channel's enable output is the inverse of its mask.
- R8: A write to port 0x0F loads all masks from a bitmap: data bit n is channel n's mask.
- R9: A write to port 0x0E clears all four masks.
- R10: A write to port 0x0D clears the byte pointer and sets all four masks. Address, count, page and mode contents are kept.
- R11: A write to a port not listed above, or any cycle with the write strobe low, changes no output and no byte-pointer state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| io_addr | input | 8 | I/O port address |
| io_wr | input | 1 | Write strobe, one write per cycle it is high |
| io_wdata | input | 8 | Write data byte |
| ch_start_addr | output | 96 | Per channel {page, base address}, channel n at bits 24n+23:24n |
| ch_count | output | 64 | Per channel base count, channel n at bits 16n+15:16n |
| ch_cur_addr | output | 64 | Per channel current address copy |
| ch_cur_count | output | 64 | Per channel current count copy |
| ch_dir | output | 8 | Per channel direction field, 2 bits each |
| ch_autoinit | output | 4 | Per channel auto-initialisation flag |
| ch_decr | output | 4 | Per channel decrementing-address flag |
| ch_xfer | output | 8 | Per channel transfer type, 2 bits each |
| ch_enable | output | 4 | Per channel enable, high when unmasked |

## Verification
The bench aims at the shared byte pointer. It interleaves writes to different channels and to address and count ports, so a design with one pointer per port would put a byte in the low half where the high half is expected. It checks that a master reset clears the pointer and keeps the register contents: a design that forgot the pointer would misplace the next byte, and one that cleared the registers would lose the programmed address. It programs each page port and each mode channel and checks that no other channel moves, which catches a swapped page decode or a mode write that ignores the channel field. The bitmap, single-mask and clear-all mask ports are exercised in an order where each write's effect is distinct, and writes to unused ports and cycles with the strobe low are checked to leave every output unchanged.

// File: rtl/dma_regs_pkg.sv
package dma_regs_pkg;

  localparam int CH_W   = 2;
  localparam int MODE_W = 6;

  localparam logic [7:0] PORT_MASK_ONE  = 8'h0A;
  localparam logic [7:0] PORT_MODE      = 8'h0B;
  localparam logic [7:0] PORT_PTR_CLR   = 8'h0C;
  localparam logic [7:0] PORT_SOFT_RST  = 8'h0D;
  localparam logic [7:0] PORT_MASK_NONE = 8'h0E;
  localparam logic [7:0] PORT_MASK_MAP  = 8'h0F;

  typedef struct packed {
    logic [1:0] xfer;
    logic       decr;
    logic       autoinit;
    logic [1:0] dir;
  } mode_t;

  function automatic logic [7:0] page_port_of(input int ch);
    case (ch)
      0:       return 8'h87;
      1:       return 8'h83;
      2:       return 8'h81;
      3:       return 8'h82;
      default: return 8'hFF;
    endcase
  endfunction

  // Data bits 7:2 of a mode write, from the top down
  function automatic mode_t mode_from_bits(input logic [MODE_W-1:0] b);
    mode_t m;
    m.xfer     = b[5:4];
    m.decr     = b[3];
    m.autoinit = b[2];
    m.dir      = b[1:0];
    return m;
  endfunction

endpackage

// File: rtl/dma_port_decode.sv
module dma_port_decode
  import dma_regs_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic              io_wr,
  input  logic [7:0]        io_addr,
  output logic [NUM_CH-1:0] wr_addr,
  output logic [NUM_CH-1:0] wr_cnt,
  output logic [NUM_CH-1:0] wr_page,
  output logic              wr_mode,
  output logic              wr_mask_one,
  output logic              wr_ptr_clr,
  output logic              wr_soft_rst,
  output logic              wr_mask_none,
  output logic              wr_mask_map,
  output logic              wr_word
);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    assign wr_addr[g] = io_wr && (io_addr == 8'(2 * g));
    assign wr_cnt[g]  = io_wr && (io_addr == 8'(2 * g + 1));
    assign wr_page[g] = io_wr && (io_addr == page_port_of(g));
  end

  assign wr_mode      = io_wr && (io_addr == PORT_MODE);
  assign wr_mask_one  = io_wr && (io_addr == PORT_MASK_ONE);
  assign wr_ptr_clr   = io_wr && (io_addr == PORT_PTR_CLR);
  assign wr_soft_rst  = io_wr && (io_addr == PORT_SOFT_RST);
  assign wr_mask_none = io_wr && (io_addr == PORT_MASK_NONE);
  assign wr_mask_map  = io_wr && (io_addr == PORT_MASK_MAP);
  assign wr_word      = (|wr_addr) || (|wr_cnt);

endmodule

// File: rtl/dma_byte_ptr.sv
module dma_byte_ptr (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic flip,
  output logic hi_byte
);

  logic ptr_q, ptr_d, ptr_en;

  always_comb begin
    ptr_en = clr || flip;
    ptr_d  = clr ? 1'b0 : !ptr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= 1'b0;
    else if (ptr_en) ptr_q <= ptr_d;
  end

  assign hi_byte = ptr_q;

  // R4: each word write flips the pointer
  a_r4_flip: assert property (@(posedge clk) disable iff (!rst_n)
    (flip && !clr) |=> (hi_byte != $past(hi_byte)));
  // R4 / R10: clear port and soft reset leave the pointer low
  a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !hi_byte);
  // R11: no strobe, no change
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !flip) |=> $stable(hi_byte));

endmodule

// File: rtl/dma_chan_bank.sv
module dma_chan_bank
  import dma_regs_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int PAGE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hi_byte,
  input  logic [7:0]        wdata,
  input  logic              wr_addr,
  input  logic              wr_cnt,
  input  logic              wr_page,
  input  logic              wr_mode,
  input  logic [MODE_W-1:0] mode_bits,
  input  logic              mask_we,
  input  logic              mask_d,
  output logic [WORD_W-1:0] base_addr,
  output logic [WORD_W-1:0] cur_addr,
  output logic [WORD_W-1:0] base_cnt,
  output logic [WORD_W-1:0] cur_cnt,
  output logic [PAGE_W-1:0] page,
  output mode_t             mode,
  output logic              masked
);

  localparam int BYTE_W = WORD_W / 2;

  logic [WORD_W-1:0] addr_q, addr_cur_q, cnt_q, cnt_cur_q;
  logic [WORD_W-1:0] addr_d, cnt_d;
  logic [PAGE_W-1:0] page_q;
  mode_t             mode_q, mode_d;
  logic              mask_q;

  // Next-state: merge the incoming byte into the selected half
  always_comb begin
    addr_d = hi_byte ? {wdata[BYTE_W-1:0], addr_q[BYTE_W-1:0]}
                     : {addr_q[WORD_W-1:BYTE_W], wdata[BYTE_W-1:0]};
    cnt_d  = hi_byte ? {wdata[BYTE_W-1:0], cnt_q[BYTE_W-1:0]}
                     : {cnt_q[WORD_W-1:BYTE_W], wdata[BYTE_W-1:0]};
    mode_d = mode_from_bits(mode_bits);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q     <= '0;
      addr_cur_q <= '0;
    end else if (wr_addr) begin
      addr_q     <= addr_d;
      addr_cur_q <= addr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      cnt_cur_q <= '0;
    end else if (wr_cnt) begin
      cnt_q     <= cnt_d;
      cnt_cur_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       page_q <= '0;
    else if (wr_page) page_q <= wdata[PAGE_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= '0;
    else if (wr_mode) mode_q <= mode_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= 1'b1;
    else if (mask_we) mask_q <= mask_d;
  end

  assign base_addr = addr_q;
  assign cur_addr  = addr_cur_q;
  assign base_cnt  = cnt_q;
  assign cur_cnt   = cnt_cur_q;
  assign page      = page_q;
  assign mode      = mode_q;
  assign masked    = mask_q;

  // R2: low-byte address write keeps the high byte
  a_r2_addr_low: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_addr && !hi_byte) |=>
      (base_addr[BYTE_W-1:0] == $past(wdata[BYTE_W-1:0])) &&
      (base_addr[WORD_W-1:BYTE_W] == $past(base_addr[WORD_W-1:BYTE_W])));
  // R2: high-byte address write keeps the low byte
  a_r2_addr_high: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_addr && hi_byte) |=>
      (base_addr[WORD_W-1:BYTE_W] == $past(wdata[BYTE_W-1:0])) &&
      (base_addr[BYTE_W-1:0] == $past(base_addr[BYTE_W-1:0])));
  // R2: current address follows base on a load
  a_r2_cur_addr: assert property (@(posedge clk) disable iff (!rst_n)
    wr_addr |=> (cur_addr == base_addr));
  // R3: current count follows base on a load
  a_r3_cur_cnt: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt |=> (cur_cnt == base_cnt));
  // R5: page takes the written byte
  a_r5_page: assert property (@(posedge clk) disable iff (!rst_n)
    wr_page |=> (page == $past(wdata[PAGE_W-1:0])));
  // R6: mode holds unless its own channel is written
  a_r6_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_mode |=> $stable(mode));

endmodule

// File: rtl/dma_cfg_regfile.sv
module dma_cfg_regfile
  import dma_regs_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int WORD_W = 16,
  parameter int PAGE_W = 8
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [7:0]                       io_addr,
  input  logic                             io_wr,
  input  logic [7:0]                       io_wdata,
  output logic [NUM_CH*(PAGE_W+WORD_W)-1:0] ch_start_addr,
  output logic [NUM_CH*WORD_W-1:0]         ch_count,
  output logic [NUM_CH*WORD_W-1:0]         ch_cur_addr,
  output logic [NUM_CH*WORD_W-1:0]         ch_cur_count,
  output logic [NUM_CH*2-1:0]              ch_dir,
  output logic [NUM_CH-1:0]                ch_autoinit,
  output logic [NUM_CH-1:0]                ch_decr,
  output logic [NUM_CH*2-1:0]              ch_xfer,
  output logic [NUM_CH-1:0]                ch_enable
);

  localparam int START_W = PAGE_W + WORD_W;

  // Reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_q_n = rst_sync_q[1];

  logic [NUM_CH-1:0] wr_addr, wr_cnt, wr_page;
  logic wr_mode, wr_mask_one, wr_ptr_clr, wr_soft_rst;
  logic wr_mask_none, wr_mask_map, wr_word;
  logic hi_byte;
  logic [NUM_CH-1:0] mask_vec;

  dma_port_decode #(.NUM_CH(NUM_CH)) u_decode (
    .io_wr        (io_wr),
    .io_addr      (io_addr),
    .wr_addr      (wr_addr),
    .wr_cnt       (wr_cnt),
    .wr_page      (wr_page),
    .wr_mode      (wr_mode),
    .wr_mask_one  (wr_mask_one),
    .wr_ptr_clr   (wr_ptr_clr),
    .wr_soft_rst  (wr_soft_rst),
    .wr_mask_none (wr_mask_none),
    .wr_mask_map  (wr_mask_map),
    .wr_word      (wr_word)
  );

  dma_byte_ptr u_ptr (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .clr     (wr_ptr_clr || wr_soft_rst),
    .flip    (wr_word),
    .hi_byte (hi_byte)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    logic              sel;
    logic              mask_we, mask_d;
    logic [WORD_W-1:0] base_addr, cur_addr, base_cnt, cur_cnt;
    logic [PAGE_W-1:0] page;
    mode_t             mode;

    assign sel = (io_wdata[CH_W-1:0] == CH_W'(g));

    // Mask next-state: soft reset over clear-all over bitmap over single
    always_comb begin
      mask_we = wr_soft_rst || wr_mask_none || wr_mask_map || (wr_mask_one && sel);
      if (wr_soft_rst)       mask_d = 1'b1;
      else if (wr_mask_none) mask_d = 1'b0;
      else if (wr_mask_map)  mask_d = io_wdata[g];
      else                   mask_d = io_wdata[2];
    end

    dma_chan_bank #(.WORD_W(WORD_W), .PAGE_W(PAGE_W)) u_bank (
      .clk       (clk),
      .rst_n     (rst_q_n),
      .hi_byte   (hi_byte),
      .wdata     (io_wdata),
      .wr_addr   (wr_addr[g]),
      .wr_cnt    (wr_cnt[g]),
      .wr_page   (wr_page[g]),
      .wr_mode   (wr_mode && sel),
      .mode_bits (io_wdata[7:2]),
      .mask_we   (mask_we),
      .mask_d    (mask_d),
      .base_addr (base_addr),
      .cur_addr  (cur_addr),
      .base_cnt  (base_cnt),
      .cur_cnt   (cur_cnt),
      .page      (page),
      .mode      (mode),
      .masked    (mask_vec[g])
    );

    assign ch_start_addr[g*START_W +: START_W] = {page, base_addr};
    assign ch_count[g*WORD_W +: WORD_W]        = base_cnt;
    assign ch_cur_addr[g*WORD_W +: WORD_W]     = cur_addr;
    assign ch_cur_count[g*WORD_W +: WORD_W]    = cur_cnt;
    assign ch_dir[g*2 +: 2]                    = mode.dir;
    assign ch_xfer[g*2 +: 2]                   = mode.xfer;
    assign ch_autoinit[g]                      = mode.autoinit;
    assign ch_decr[g]                          = mode.decr;
  end

  assign ch_enable = ~mask_vec;

  // R11: at most one port strobe per cycle
  a_r11_one_port: assert property (@(posedge clk) disable iff (!rst_q_n)
    $onehot0({wr_addr, wr_cnt, wr_page, wr_mode, wr_mask_one, wr_ptr_clr,
              wr_soft_rst, wr_mask_none, wr_mask_map}));
  // R11: idle bus leaves enables alone
  a_r11_idle: assert property (@(posedge clk) disable iff (!rst_q_n)
    !io_wr |=> $stable(ch_enable));
  // R10: soft reset disables every channel
  a_r10_soft_rst: assert property (@(posedge clk) disable iff (!rst_q_n)
    wr_soft_rst |=> (ch_enable == '0));
  // R9: clear-all enables every channel
  a_r9_unmask_all: assert property (@(posedge clk) disable iff (!rst_q_n)
    wr_mask_none |=> (ch_enable == '1));
  // R8: bitmap load
  a_r8_map: assert property (@(posedge clk) disable iff (!rst_q_n)
    wr_mask_map |=> (ch_enable == ~$past(io_wdata[NUM_CH-1:0])));
  // R7: single mask write reaches only the named channel
  a_r7_single: assert property (@(posedge clk) disable iff (!rst_q_n)
    wr_mask_one |=> (ch_enable[$past(io_wdata[CH_W-1:0])] == !$past(io_wdata[2])));

endmodule

// File: tb/test_dma_cfg_regfile.sv
module test_dma_cfg_regfile;

  localparam int NCH = 4;
  localparam logic [2:0] F_START = 3'd0, F_CNT = 3'd1, F_MODE = 3'd2,
                         F_EN = 3'd3, F_CUR = 3'd4, F_CCNT = 3'd5;

  logic clk, rst_n, io_wr;
  logic [7:0] io_addr, io_wdata;
  logic [95:0] ch_start_addr;
  logic [63:0] ch_count, ch_cur_addr, ch_cur_count;
  logic [7:0]  ch_dir, ch_xfer;
  logic [3:0]  ch_autoinit, ch_decr, ch_enable;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 0;

  dma_cfg_regfile i_dma_cfg_regfile (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_wdata(io_wdata),
    .ch_start_addr(ch_start_addr), .ch_count(ch_count), .ch_cur_addr(ch_cur_addr),
    .ch_cur_count(ch_cur_count), .ch_dir(ch_dir), .ch_autoinit(ch_autoinit),
    .ch_decr(ch_decr), .ch_xfer(ch_xfer), .ch_enable(ch_enable)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  // {req[3:0], addr[7:0], data[7:0], ch[1:0], field[2:0], expected[23:0]}
  localparam int NVEC = 31;
  localparam logic [48:0] VEC [NVEC] = '{
    {4'd4,  8'h0C, 8'h55, 2'd0, F_START, 24'h000000},  // R4 pointer clear
    {4'd2,  8'h00, 8'h34, 2'd0, F_START, 24'h000034},  // R2 low byte
    {4'd2,  8'h00, 8'h12, 2'd0, F_START, 24'h001234},  // R2 high byte
    {4'd5,  8'h87, 8'h0A, 2'd0, F_START, 24'h0A1234},  // R5 page ch0
    {4'd3,  8'h01, 8'hFF, 2'd0, F_CNT,   24'h0000FF},  // R3 low byte
    {4'd3,  8'h01, 8'h01, 2'd0, F_CNT,   24'h0001FF},  // R3 high byte
    {4'd4,  8'h02, 8'h78, 2'd1, F_START, 24'h000078},  // R4 shared pointer, low
    {4'd4,  8'h05, 8'h9A, 2'd2, F_CNT,   24'h009A00},  // R4 other port gets high
    {4'd4,  8'h0C, 8'h00, 2'd2, F_CNT,   24'h009A00},  // R4 clear again
    {4'd3,  8'h07, 8'h11, 2'd3, F_CNT,   24'h000011},  // R3 ch3 low
    {4'd3,  8'h07, 8'h22, 2'd3, F_CNT,   24'h002211},  // R3 ch3 high
    {4'd2,  8'h06, 8'hCD, 2'd3, F_START, 24'h0000CD},  // R2 ch3 low
    {4'd5,  8'h82, 8'h3F, 2'd3, F_START, 24'h3F00CD},  // R5 page ch3
    {4'd2,  8'h06, 8'hAB, 2'd3, F_CUR,   24'h00ABCD},  // R2 current copy
    {4'd3,  8'h10, 8'h00, 2'd3, F_CCNT,  24'h002211},  // R3 current count
    {4'd5,  8'h83, 8'h44, 2'd1, F_START, 24'h440078},  // R5 page ch1
    {4'd5,  8'h81, 8'h55, 2'd2, F_START, 24'h550000},  // R5 page ch2
    {4'd6,  8'h0B, 8'h56, 2'd2, F_MODE,  24'h000015},  // R6 ch2 single, auto, into memory
    {4'd6,  8'h0B, 8'hE4, 2'd0, F_MODE,  24'h000039},  // R6 ch0 cascade, decr
    {4'd6,  8'h0B, 8'h8B, 2'd2, F_MODE,  24'h000015},  // R6 ch3 write leaves ch2
    {4'd11, 8'h10, 8'hFF, 2'd3, F_MODE,  24'h000022},  // R11 unused port, ch3 mode
    {4'd9,  8'h0E, 8'h00, 2'd0, F_EN,    24'h00000F},  // R9 clear all masks
    {4'd7,  8'h0A, 8'h05, 2'd0, F_EN,    24'h00000D},  // R7 mask ch1
    {4'd7,  8'h0A, 8'h01, 2'd0, F_EN,    24'h00000F},  // R7 unmask ch1
    {4'd8,  8'h0F, 8'h0A, 2'd0, F_EN,    24'h000005},  // R8 bitmap
    {4'd7,  8'h0A, 8'h06, 2'd0, F_EN,    24'h000001},  // R7 mask ch2
    {4'd2,  8'h04, 8'h66, 2'd2, F_START, 24'h550066},  // R2 leaves pointer set
    {4'd10, 8'h0D, 8'h00, 2'd0, F_EN,    24'h000000},  // R10 all masked
    {4'd10, 8'h00, 8'h99, 2'd0, F_START, 24'h0A1299},  // R10 pointer cleared, page kept
    {4'd10, 8'h84, 8'h00, 2'd2, F_MODE,  24'h000015},  // R10 mode kept; R11 unused
    {4'd2,  8'h10, 8'h00, 2'd0, F_CUR,   24'h001299}   // R2 current after reset
  };

  function automatic logic [23:0] peek(input int ch, input logic [2:0] fld);
    case (fld)
      F_START: return ch_start_addr[ch*24 +: 24];
      F_CNT:   return {8'h00, ch_count[ch*16 +: 16]};
      F_MODE:  return {18'h0, ch_xfer[ch*2 +: 2], ch_decr[ch], ch_autoinit[ch], ch_dir[ch*2 +: 2]};
      F_EN:    return {20'h0, ch_enable};
      F_CUR:   return {8'h00, ch_cur_addr[ch*16 +: 16]};
      default: return {8'h00, ch_cur_count[ch*16 +: 16]};
    endcase
  endfunction

  task automatic check(input int req, input string what, input logic [23:0] act,
                       input logic [23:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic io_write(input logic [7:0] a, input logic [7:0] d);
    io_addr  = a;
    io_wdata = d;
    io_wr    = 1'b1;
    @(posedge clk);
    @(negedge clk);
    io_wr    = 1'b0;
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    io_wr = 1'b0; io_addr = 8'h00; io_wdata = 8'h00;
    rst_n = 1'b1;
    #1 rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check(1, "start address after reset", ch_start_addr[23:0], 24'h0);
    check(1, "all start addresses zero", {23'h0, |ch_start_addr}, 24'h0);
    check(1, "counts zero", {23'h0, |{ch_count, ch_cur_count, ch_cur_addr}}, 24'h0);
    check(1, "modes zero", {23'h0, |{ch_dir, ch_xfer, ch_autoinit, ch_decr}}, 24'h0);
    check(1, "all channels masked", {20'h0, ch_enable}, 24'h0);

    for (int i = 0; i < NVEC; i++) begin
      logic [48:0] v;
      v = VEC[i];
      io_write(v[44:37], v[36:29]);
      check(int'(v[48:45]), $sformatf("vector %0d", i), peek(int'(v[28:27]), v[26:24]), v[23:0]);
    end

    // R11 strobe low: address port and data present, nothing changes
    io_addr = 8'h00; io_wdata = 8'hEE; io_wr = 1'b0;
    repeat (3) @(negedge clk);
    check(11, "strobe low keeps ch0 address", peek(0, F_START), 24'h0A1299);
    // R11 strobe low must not flip the pointer: next ch0 write is high byte
    io_write(8'h00, 8'h5A);
    check(11, "pointer unchanged by idle bus", peek(0, F_START), 24'h0A5A99);

    // R1 reset asserted mid-run clears contents at once
    rst_n = 1'b0;
    #1;
    check(1, "mid-run reset clears address", peek(0, F_START), 24'h0);
    check(1, "mid-run reset masks channels", {20'h0, ch_enable}, 24'h0);
    check(1, "mid-run reset clears mode", peek(2, F_MODE), 24'h0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R4 pointer starts low after reset
    io_write(8'h02, 8'h3C);
    check(4, "pointer low after reset", peek(1, F_START), 24'h00003C);

    done = 1;
    summary();
  end

endmodule